// File: doc/BRIEF.md
# Coherence Message Channel Fabric

This block moves coherence traffic between a single directory-side parent and a set of child caches. Every child owns one upward path into the parent and one downward path out of it. Each path holds two independent queues, one for requests and one for responses. A response therefore always has a way out, even when requests on the same path cannot move. Upward requests from all children meet at one parent port, and upward responses meet at a second parent port. Each of these merges is arbitrated round-robin.

The fabric makes no protocol decisions. It stores messages, steers each one by its command or its destination, and applies one ordering rule: a request is held back while a response for the same address is still queued on the same path. All data ports are valid/ready streams. A transfer happens on a rising clock edge where valid and ready are both high. A source that sees ready low keeps offering its message, and nothing is lost. Every ready is combinational from the queue state and, on the steering ports, from the offered command or destination. The child count must be a power of two, at least 2.

Message layout, MSB first: bit 51 is the command (0 request, 1 response); bits 50:35 the address; bits 34:33 the coherence state (0 invalid, 1 shared, 2 modified); bit 32 the data-present flag; bits 31:0 the data.

Top module: `coh_xbar`

## Requirements
- R1: In the cycle after reset is released, every output valid is low and every input ready is high.
- R2: A message from a child with bit 51 set leaves only on the parent response port. One with bit 51 clear leaves only on the parent request port.
- R3: A response from a child reaches the parent response port while a request from the same child is stalled by pu_req_ready low.
- R4: On any single path, messages of one class leave in the order in which they were accepted.
- R5: A request is not offered at its path's output while the response queue of that path holds an entry with the same address (bits 50:35).
- R6: The parent request port grants the first eligible child at or after a rotating pointer. After each accepted transfer the pointer moves to the child after the one granted.
- R7: The parent response port uses its own rotating pointer with the same rule as R6.
- R8: A child that holds its downward ready low stalls only its own queues. Other children keep receiving.
- R9: An input ready is high exactly when the queue that the offered message would enter has a free entry. A pop in the same cycle does not free that entry early.
- R10: A message accepted on an edge can leave no earlier than the following cycle.
- R11: A parent message with destination d is delivered only on child d's downward port of the same class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cu_valid | input | N_CHILD | Child i offers a message upward |
| cu_ready | output | N_CHILD | Upward queue for child i's offered class has room |
| cu_msg | input | N_CHILD*52 | Upward messages, child i in slice i |
| pu_req_valid | output | 1 | Merged upward request available |
| pu_req_ready | input | 1 | Parent accepts the upward request |
| pu_req_src | output | log2(N_CHILD) | Child that sent the upward request |
| pu_req_msg | output | 52 | Upward request message |
| pu_rsp_valid | output | 1 | Merged upward response available |
| pu_rsp_ready | input | 1 | Parent accepts the upward response |
| pu_rsp_src | output | log2(N_CHILD) | Child that sent the upward response |
| pu_rsp_msg | output | 52 | Upward response message |
| pd_req_valid | input | 1 | Parent offers a downward request |
| pd_req_ready | output | 1 | Destination request queue has room |
| pd_req_dst | input | log2(N_CHILD) | Destination child of the downward request |
| pd_req_msg | input | 52 | Downward request message |
| pd_rsp_valid | input | 1 | Parent offers a downward response |
| pd_rsp_ready | output | 1 | Destination response queue has room |
| pd_rsp_dst | input | log2(N_CHILD) | Destination child of the downward response |
| pd_rsp_msg | input | 52 | Downward response message |
| cd_req_valid | output | N_CHILD | Downward request available for child i |
| cd_req_ready | input | N_CHILD | Child i accepts its request |
| cd_req_msg | output | N_CHILD*52 | Downward requests, child i in slice i |
| cd_rsp_valid | output | N_CHILD | Downward response available for child i |
| cd_rsp_ready | input | N_CHILD | Child i accepts its response |
| cd_rsp_msg | output | N_CHILD*52 | Downward responses, child i in slice i |

## Verification
Readies react in the same cycle as the offered command or destination. A message accepted on an edge appears at its output one cycle later, after a single register. A request that a response has held back becomes eligible on the cycle after that response leaves, because the hazard test sees the queue as it stood before the edge. The bench drives inputs at the falling edge and compares every output 1 ns later against a queue model that is advanced once per cycle using only the sizes and contents it held before that edge. This keeps each expectation aligned to the cycle the register count dictates. Directed sequences pin down the one-cycle delay, the response bypass, the same-address hold and its release cycle.

// File: rtl/coh_pkg.sv
package coh_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 32;
  parameter int ST_W   = 2;

  typedef enum logic {
    CMD_REQ = 1'b0,
    CMD_RSP = 1'b1
  } cmd_e;

  // Field order fixes the bit positions the neighbours decode.
  typedef struct packed {
    cmd_e              cmd;
    logic [ADDR_W-1:0] addr;
    logic [ST_W-1:0]   cst;
    logic              has_data;
    logic [DATA_W-1:0] data;
  } msg_t;

  localparam int MSG_W = $bits(msg_t);
endpackage

// File: rtl/coh_fifo.sv
// Message queue with a per-entry valid bit and an address probe
// over all occupied entries.
module coh_fifo
  import coh_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  msg_t              din,
  input  logic              pop,
  output msg_t              dout,
  output logic              full,
  output logic              empty,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  msg_t             mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [AW-1:0]    wp, rp;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      wp  <= '0;
      rp  <= '0;
    end else begin
      if (push) begin
        mem[wp] <= din;
        vld[wp] <= 1'b1;
        wp      <= (wp == LAST) ? '0 : wp + 1'b1;
      end
      if (pop) begin
        vld[rp] <= 1'b0;
        rp      <= (rp == LAST) ? '0 : rp + 1'b1;
      end
    end
  end

  assign full  = vld[wp];
  assign empty = !vld[rp];
  assign dout  = mem[rp];

  always_comb begin
    probe_hit = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (vld[k] && (mem[k].addr == probe_addr)) probe_hit = 1'b1;
    end
  end
endmodule

// File: rtl/coh_lane.sv
// One directed path: a request queue, a response queue and the
// same-address hold that keeps a request behind an older response.
module coh_lane
  import coh_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_push,
  input  msg_t req_in,
  output logic req_full,
  input  logic rsp_push,
  input  msg_t rsp_in,
  output logic rsp_full,
  output msg_t req_head,
  output logic req_elig,
  output logic req_hz,
  input  logic req_pop,
  output msg_t rsp_head,
  output logic rsp_avail,
  input  logic rsp_pop
);
  logic req_empty, rsp_empty, addr_hit, req_probe_unused;

  coh_fifo #(.DEPTH(DEPTH)) req_q (
    .clk(clk), .rst(rst), .push(req_push), .din(req_in), .pop(req_pop),
    .dout(req_head), .full(req_full), .empty(req_empty),
    .probe_addr(rsp_head.addr), .probe_hit(req_probe_unused)
  );

  coh_fifo #(.DEPTH(DEPTH)) rsp_q (
    .clk(clk), .rst(rst), .push(rsp_push), .din(rsp_in), .pop(rsp_pop),
    .dout(rsp_head), .full(rsp_full), .empty(rsp_empty),
    .probe_addr(req_head.addr), .probe_hit(addr_hit)
  );

  assign req_hz    = !req_empty && addr_hit;
  assign req_elig  = !req_empty && !addr_hit;
  assign rsp_avail = !rsp_empty;
endmodule

// File: rtl/coh_rr_arb.sv
// Rotating-priority selector; the pointer moves past the winner on take.
module coh_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [IW-1:0] ptr;

  always_comb begin
    int j;
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any    = 1'b1;
        gnt[j] = 1'b1;
        idx    = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (take && any) ptr <= (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/coh_xbar.sv
module coh_xbar
  import coh_pkg::*;
#(
  parameter int N_CHILD = 4,   // power of two, at least 2
  parameter int DEPTH   = 4,
  localparam int ID_W   = $clog2(N_CHILD),
  localparam int MW     = MSG_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_CHILD-1:0]    cu_valid,
  output logic [N_CHILD-1:0]    cu_ready,
  input  logic [N_CHILD*MW-1:0] cu_msg,
  output logic                  pu_req_valid,
  input  logic                  pu_req_ready,
  output logic [ID_W-1:0]       pu_req_src,
  output logic [MW-1:0]         pu_req_msg,
  output logic                  pu_rsp_valid,
  input  logic                  pu_rsp_ready,
  output logic [ID_W-1:0]       pu_rsp_src,
  output logic [MW-1:0]         pu_rsp_msg,
  input  logic                  pd_req_valid,
  output logic                  pd_req_ready,
  input  logic [ID_W-1:0]       pd_req_dst,
  input  logic [MW-1:0]         pd_req_msg,
  input  logic                  pd_rsp_valid,
  output logic                  pd_rsp_ready,
  input  logic [ID_W-1:0]       pd_rsp_dst,
  input  logic [MW-1:0]         pd_rsp_msg,
  output logic [N_CHILD-1:0]    cd_req_valid,
  input  logic [N_CHILD-1:0]    cd_req_ready,
  output logic [N_CHILD*MW-1:0] cd_req_msg,
  output logic [N_CHILD-1:0]    cd_rsp_valid,
  input  logic [N_CHILD-1:0]    cd_rsp_ready,
  output logic [N_CHILD*MW-1:0] cd_rsp_msg
);
  // Upward side
  msg_t               up_req_head [N_CHILD];
  msg_t               up_rsp_head [N_CHILD];
  logic [N_CHILD-1:0] up_req_full, up_rsp_full, up_req_push, up_rsp_push;
  logic [N_CHILD-1:0] up_elig, up_rsp_av, up_hz, up_req_pop, up_rsp_pop;
  logic [N_CHILD-1:0] up_req_gnt, up_rsp_gnt;
  logic               up_req_any, up_rsp_any;
  logic [ID_W-1:0]    up_req_idx, up_rsp_idx;

  // Downward side
  msg_t               dn_req_head [N_CHILD];
  msg_t               dn_rsp_head [N_CHILD];
  logic [N_CHILD-1:0] dn_req_full, dn_rsp_full, dn_req_push, dn_rsp_push;
  logic [N_CHILD-1:0] dn_elig, dn_rsp_av, dn_hz_unused, dn_req_pop, dn_rsp_pop;

  for (genvar i = 0; i < N_CHILD; i++) begin : g_up
    msg_t m;
    logic is_rsp;
    assign m      = msg_t'(cu_msg[i*MW +: MW]);
    assign is_rsp = (m.cmd == CMD_RSP);

    assign up_req_push[i] = cu_valid[i] && !is_rsp && !up_req_full[i];
    assign up_rsp_push[i] = cu_valid[i] &&  is_rsp && !up_rsp_full[i];
    assign cu_ready[i]    = is_rsp ? !up_rsp_full[i] : !up_req_full[i];
    assign up_req_pop[i]  = up_req_gnt[i] && pu_req_ready;
    assign up_rsp_pop[i]  = up_rsp_gnt[i] && pu_rsp_ready;

    coh_lane #(.DEPTH(DEPTH)) lane_i (
      .clk(clk), .rst(rst),
      .req_push(up_req_push[i]), .req_in(m), .req_full(up_req_full[i]),
      .rsp_push(up_rsp_push[i]), .rsp_in(m), .rsp_full(up_rsp_full[i]),
      .req_head(up_req_head[i]), .req_elig(up_elig[i]), .req_hz(up_hz[i]),
      .req_pop(up_req_pop[i]),
      .rsp_head(up_rsp_head[i]), .rsp_avail(up_rsp_av[i]),
      .rsp_pop(up_rsp_pop[i])
    );
  end

  coh_rr_arb #(.N(N_CHILD)) req_arb (
    .clk(clk), .rst(rst), .req(up_elig), .take(pu_req_ready),
    .gnt(up_req_gnt), .idx(up_req_idx), .any(up_req_any)
  );

  coh_rr_arb #(.N(N_CHILD)) rsp_arb (
    .clk(clk), .rst(rst), .req(up_rsp_av), .take(pu_rsp_ready),
    .gnt(up_rsp_gnt), .idx(up_rsp_idx), .any(up_rsp_any)
  );

  assign pu_req_valid = up_req_any;
  assign pu_req_src   = up_req_idx;
  assign pu_req_msg   = up_req_head[up_req_idx];
  assign pu_rsp_valid = up_rsp_any;
  assign pu_rsp_src   = up_rsp_idx;
  assign pu_rsp_msg   = up_rsp_head[up_rsp_idx];

  for (genvar j = 0; j < N_CHILD; j++) begin : g_dn
    assign dn_req_push[j] = pd_req_valid && (pd_req_dst == ID_W'(j)) && !dn_req_full[j];
    assign dn_rsp_push[j] = pd_rsp_valid && (pd_rsp_dst == ID_W'(j)) && !dn_rsp_full[j];
    assign dn_req_pop[j]  = dn_elig[j] && cd_req_ready[j];
    assign dn_rsp_pop[j]  = dn_rsp_av[j] && cd_rsp_ready[j];

    coh_lane #(.DEPTH(DEPTH)) lane_j (
      .clk(clk), .rst(rst),
      .req_push(dn_req_push[j]), .req_in(msg_t'(pd_req_msg)), .req_full(dn_req_full[j]),
      .rsp_push(dn_rsp_push[j]), .rsp_in(msg_t'(pd_rsp_msg)), .rsp_full(dn_rsp_full[j]),
      .req_head(dn_req_head[j]), .req_elig(dn_elig[j]), .req_hz(dn_hz_unused[j]),
      .req_pop(dn_req_pop[j]),
      .rsp_head(dn_rsp_head[j]), .rsp_avail(dn_rsp_av[j]),
      .rsp_pop(dn_rsp_pop[j])
    );

    assign cd_req_valid[j]         = dn_elig[j];
    assign cd_req_msg[j*MW +: MW]  = dn_req_head[j];
    assign cd_rsp_valid[j]         = dn_rsp_av[j];
    assign cd_rsp_msg[j*MW +: MW]  = dn_rsp_head[j];
  end

  assign pd_req_ready = !dn_req_full[pd_req_dst];
  assign pd_rsp_ready = !dn_rsp_full[pd_rsp_dst];
endmodule

// File: rtl/coh_xbar_chk.sv
module coh_xbar_chk
  import coh_pkg::*;
#(
  parameter int N_CHILD = 4,
  localparam int ID_W   = $clog2(N_CHILD),
  localparam int MW     = MSG_W
) (
  input logic               clk,
  input logic               rst,
  input logic               pu_req_valid,
  input logic [ID_W-1:0]    pu_req_src,
  input logic [MW-1:0]      pu_req_msg,
  input logic               pu_rsp_valid,
  input logic [MW-1:0]      pu_rsp_msg,
  input logic [N_CHILD-1:0] cd_req_valid,
  input logic [N_CHILD-1:0] cd_rsp_valid,
  input logic [N_CHILD-1:0] cu_ready,
  input logic               pd_req_ready,
  input logic               pd_rsp_ready,
  input logic [N_CHILD-1:0] up_req_gnt,
  input logic [N_CHILD-1:0] up_rsp_gnt,
  input logic [N_CHILD-1:0] up_hz
);
  logic just_out;
  always_ff @(posedge clk) just_out <= rst;

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    just_out |-> (!pu_req_valid && !pu_rsp_valid && (cd_req_valid == '0) &&
                  (cd_rsp_valid == '0) && (&cu_ready) && pd_req_ready && pd_rsp_ready));

  assert_req_port_class_R2: assert property (@(posedge clk) disable iff (rst)
    pu_req_valid |-> (pu_req_msg[MW-1] == 1'b0));

  assert_rsp_port_class_R2: assert property (@(posedge clk) disable iff (rst)
    pu_rsp_valid |-> (pu_rsp_msg[MW-1] == 1'b1));

  assert_no_hazard_issue_R5: assert property (@(posedge clk) disable iff (rst)
    pu_req_valid |-> !up_hz[pu_req_src]);

  assert_single_req_grant_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(up_req_gnt));

  assert_grant_is_source_R6: assert property (@(posedge clk) disable iff (rst)
    pu_req_valid |-> up_req_gnt[pu_req_src]);

  assert_single_rsp_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(up_rsp_gnt));
endmodule

bind coh_xbar coh_xbar_chk #(.N_CHILD(N_CHILD)) u_chk (.*);

// File: tb/coh_xbar_tb_top.sv
module coh_xbar_tb_top;
  import coh_pkg::*;
  localparam int N  = 4;
  localparam int D  = 4;
  localparam int IW = 2;
  localparam int MW = MSG_W;
  typedef logic [MW-1:0] m_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic [N-1:0] cu_valid, cu_ready, cd_req_valid, cd_req_ready, cd_rsp_valid, cd_rsp_ready;
  logic [N*MW-1:0] cu_msg, cd_req_msg, cd_rsp_msg;
  logic pu_req_valid, pu_req_ready, pu_rsp_valid, pu_rsp_ready;
  logic [IW-1:0] pu_req_src, pu_rsp_src, pd_req_dst, pd_rsp_dst;
  logic [MW-1:0] pu_req_msg, pu_rsp_msg, pd_req_msg, pd_rsp_msg;
  logic pd_req_valid, pd_req_ready, pd_rsp_valid, pd_rsp_ready;

  coh_xbar #(.N_CHILD(N), .DEPTH(D)) dut_i (.*);

  // next-cycle stimulus, applied at the falling edge by step()
  logic [N-1:0] nx_cu_valid, nx_cd_req_ready, nx_cd_rsp_ready;
  m_t           nx_cu_msg [N];
  logic         nx_pu_req_ready, nx_pu_rsp_ready, nx_pd_req_valid, nx_pd_rsp_valid;
  logic [IW-1:0] nx_pd_req_dst, nx_pd_rsp_dst;
  m_t           nx_pd_req_msg, nx_pd_rsp_msg;

  // reference model
  m_t uq_req [N][$];
  m_t uq_rsp [N][$];
  m_t dq_req [N][$];
  m_t dq_rsp [N][$];
  int ptr_req = 0, ptr_rsp = 0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  string phase = "reset";

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s, cycle %0d) actual=%h expected=%h", tag, phase, cyc, act, exp);
    end
  endtask

  function automatic m_t mk(bit rsp, int addr, int data);
    return {rsp, 16'(addr), 2'($urandom_range(0, 2)), 1'($urandom_range(0, 1)), 32'(data)};
  endfunction

  function automatic logic [15:0] addr_of(m_t m);
    return m[MW-2 -: 16];
  endfunction

  function automatic bit up_hold(int i);
    if (uq_req[i].size() == 0) return 0;
    for (int k = 0; k < uq_rsp[i].size(); k++)
      if (addr_of(uq_rsp[i][k]) == addr_of(uq_req[i][0])) return 1;
    return 0;
  endfunction

  function automatic bit dn_hold(int j);
    if (dq_req[j].size() == 0) return 0;
    for (int k = 0; k < dq_rsp[j].size(); k++)
      if (addr_of(dq_rsp[j][k]) == addr_of(dq_req[j][0])) return 1;
    return 0;
  endfunction

  task automatic idle_nx();
    nx_cu_valid = '0; nx_pd_req_valid = 0; nx_pd_rsp_valid = 0;
    nx_pu_req_ready = 1; nx_pu_rsp_ready = 1;
    nx_cd_req_ready = '1; nx_cd_rsp_ready = '1;
    nx_pd_req_dst = '0; nx_pd_rsp_dst = '0;
    nx_pd_req_msg = mk(0, 0, 0); nx_pd_rsp_msg = mk(1, 0, 0);
    for (int i = 0; i < N; i++) nx_cu_msg[i] = mk(0, 0, 0);
  endtask

  task automatic step();
    int  sel_q, sel_s;
    bit  any_hold;
    bit  e_cu_rdy [N];
    bit  e_pdq_rdy, e_pds_rdy;
    bit  e_dq_v [N];
    @(negedge clk);
    cyc++;
    cu_valid = nx_cu_valid;
    for (int i = 0; i < N; i++) cu_msg[i*MW +: MW] = nx_cu_msg[i];
    pu_req_ready = nx_pu_req_ready; pu_rsp_ready = nx_pu_rsp_ready;
    pd_req_valid = nx_pd_req_valid; pd_req_dst = nx_pd_req_dst; pd_req_msg = nx_pd_req_msg;
    pd_rsp_valid = nx_pd_rsp_valid; pd_rsp_dst = nx_pd_rsp_dst; pd_rsp_msg = nx_pd_rsp_msg;
    cd_req_ready = nx_cd_req_ready; cd_rsp_ready = nx_cd_rsp_ready;
    #1;
    // expected outputs from the model state held before the coming edge
    sel_q = -1; sel_s = -1; any_hold = 0;
    for (int i = 0; i < N; i++) if (up_hold(i)) any_hold = 1;
    for (int k = 0; k < N; k++) begin
      int j = (ptr_req + k) % N;
      if (uq_req[j].size() > 0 && !up_hold(j)) begin sel_q = j; break; end
    end
    for (int k = 0; k < N; k++) begin
      int j = (ptr_rsp + k) % N;
      if (uq_rsp[j].size() > 0) begin sel_s = j; break; end
    end
    chk(pu_req_valid == (sel_q >= 0), any_hold ? "R5 request hold" : "R6 request merge",
        64'(pu_req_valid), 64'(sel_q >= 0));
    if (sel_q >= 0) begin
      chk(pu_req_src == IW'(sel_q), "R6 request grant", 64'(pu_req_src), 64'(sel_q));
      chk(pu_req_msg == uq_req[sel_q][0], "R4 request order", 64'(pu_req_msg), 64'(uq_req[sel_q][0]));
    end
    chk(pu_rsp_valid == (sel_s >= 0), "R7 response merge", 64'(pu_rsp_valid), 64'(sel_s >= 0));
    if (sel_s >= 0) begin
      chk(pu_rsp_src == IW'(sel_s), "R7 response grant", 64'(pu_rsp_src), 64'(sel_s));
      chk(pu_rsp_msg == uq_rsp[sel_s][0], "R4 response order", 64'(pu_rsp_msg), 64'(uq_rsp[sel_s][0]));
    end
    for (int i = 0; i < N; i++) begin
      e_cu_rdy[i] = cu_msg[i*MW + MW - 1] ? (uq_rsp[i].size() < D) : (uq_req[i].size() < D);
      chk(cu_ready[i] == e_cu_rdy[i], "R9 child ready", 64'(cu_ready[i]), 64'(e_cu_rdy[i]));
      e_dq_v[i] = dq_req[i].size() > 0 && !dn_hold(i);
      chk(cd_req_valid[i] == e_dq_v[i], "R8 child request valid", 64'(cd_req_valid[i]), 64'(e_dq_v[i]));
      if (e_dq_v[i])
        chk(cd_req_msg[i*MW +: MW] == dq_req[i][0], "R11 child request msg",
            64'(cd_req_msg[i*MW +: MW]), 64'(dq_req[i][0]));
      chk(cd_rsp_valid[i] == (dq_rsp[i].size() > 0), "R8 child response valid",
          64'(cd_rsp_valid[i]), 64'(dq_rsp[i].size() > 0));
      if (dq_rsp[i].size() > 0)
        chk(cd_rsp_msg[i*MW +: MW] == dq_rsp[i][0], "R11 child response msg",
            64'(cd_rsp_msg[i*MW +: MW]), 64'(dq_rsp[i][0]));
    end
    e_pdq_rdy = dq_req[pd_req_dst].size() < D;
    e_pds_rdy = dq_rsp[pd_rsp_dst].size() < D;
    chk(pd_req_ready == e_pdq_rdy, "R9 parent request ready", 64'(pd_req_ready), 64'(e_pdq_rdy));
    chk(pd_rsp_ready == e_pds_rdy, "R9 parent response ready", 64'(pd_rsp_ready), 64'(e_pds_rdy));
    // pops
    if (sel_q >= 0 && pu_req_ready) begin void'(uq_req[sel_q].pop_front()); ptr_req = (sel_q + 1) % N; end
    if (sel_s >= 0 && pu_rsp_ready) begin void'(uq_rsp[sel_s].pop_front()); ptr_rsp = (sel_s + 1) % N; end
    for (int i = 0; i < N; i++) begin
      if (e_dq_v[i] && cd_req_ready[i]) void'(dq_req[i].pop_front());
      if (dq_rsp[i].size() > 0 && cd_rsp_ready[i]) void'(dq_rsp[i].pop_front());
    end
    // pushes
    for (int i = 0; i < N; i++)
      if (cu_valid[i] && e_cu_rdy[i]) begin
        if (cu_msg[i*MW + MW - 1]) uq_rsp[i].push_back(cu_msg[i*MW +: MW]);
        else uq_req[i].push_back(cu_msg[i*MW +: MW]);
      end
    if (pd_req_valid && e_pdq_rdy) dq_req[pd_req_dst].push_back(pd_req_msg);
    if (pd_rsp_valid && e_pds_rdy) dq_rsp[pd_rsp_dst].push_back(pd_rsp_msg);
  endtask

  task automatic run_phase(string name, int n, int pv, int prsp, int prdy, bit stall0);
    phase = name;
    for (int c = 0; c < n; c++) begin
      for (int i = 0; i < N; i++) begin
        bit r = $urandom_range(0, 99) < prsp;
        nx_cu_valid[i] = $urandom_range(0, 99) < pv;
        nx_cu_msg[i] = mk(r, $urandom_range(0, 3), $urandom);
        nx_cd_req_ready[i] = $urandom_range(0, 99) < prdy;
        nx_cd_rsp_ready[i] = $urandom_range(0, 99) < prdy;
      end
      if (stall0) begin nx_cd_req_ready[0] = 0; nx_cd_rsp_ready[0] = 0; end
      nx_pu_req_ready = $urandom_range(0, 99) < prdy;
      nx_pu_rsp_ready = $urandom_range(0, 99) < (name == "bypass" ? 100 : prdy);
      nx_pd_req_valid = $urandom_range(0, 99) < pv;
      nx_pd_rsp_valid = $urandom_range(0, 99) < pv;
      nx_pd_req_dst = IW'($urandom_range(0, N - 1));
      nx_pd_rsp_dst = IW'($urandom_range(0, N - 1));
      nx_pd_req_msg = mk(0, $urandom_range(0, 3), $urandom);
      nx_pd_rsp_msg = mk(1, $urandom_range(0, 3), $urandom);
      step();
    end
    idle_nx();
    for (int c = 0; c < 12; c++) step();
  endtask

  initial begin
    rst = 1;
    idle_nx();
    cu_valid = '0; cu_msg = '0; pu_req_ready = 1; pu_rsp_ready = 1;
    pd_req_valid = 0; pd_rsp_valid = 0; pd_req_dst = '0; pd_rsp_dst = '0;
    pd_req_msg = '0; pd_rsp_msg = '0; cd_req_ready = '1; cd_rsp_ready = '1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    chk(!pu_req_valid && !pu_rsp_valid, "R1 parent valids idle", {pu_req_valid, pu_rsp_valid}, 0);
    chk(cd_req_valid == 0 && cd_rsp_valid == 0, "R1 child valids idle", {cd_req_valid, cd_rsp_valid}, 0);
    chk(&cu_ready && pd_req_ready && pd_rsp_ready, "R1 readies high",
        {cu_ready, pd_req_ready, pd_rsp_ready}, 64'h3f);

    // R10 and R2: one response from child 2
    phase = "directed";
    nx_cu_valid[2] = 1; nx_cu_msg[2] = mk(1, 9, 32'h1111);
    step();
    chk(!pu_rsp_valid, "R10 no cut-through", 64'(pu_rsp_valid), 0);
    idle_nx(); step();
    chk(pu_rsp_valid && addr_of(pu_rsp_msg) == 16'd9, "R2 response port", 64'(pu_rsp_msg), 64'd9);
    chk(!pu_req_valid, "R2 request port silent", 64'(pu_req_valid), 0);

    // R4: two requests from child 1 leave in order
    idle_nx(); nx_pu_req_ready = 0;
    nx_cu_valid[1] = 1; nx_cu_msg[1] = mk(0, 1, 32'hA); step();
    nx_cu_msg[1] = mk(0, 1, 32'hB); step();
    idle_nx(); step();
    chk(pu_req_msg[31:0] == 32'hA, "R4 first request", 64'(pu_req_msg[31:0]), 64'hA);
    step();
    chk(pu_req_msg[31:0] == 32'hB, "R4 second request", 64'(pu_req_msg[31:0]), 64'hB);
    step();

    // R3: response passes a stalled request
    idle_nx(); nx_pu_req_ready = 0;
    nx_cu_valid[0] = 1; nx_cu_msg[0] = mk(0, 5, 32'h5); step();
    nx_cu_msg[0] = mk(1, 6, 32'h6); step();
    idle_nx(); nx_pu_req_ready = 0; step();
    chk(pu_rsp_valid && addr_of(pu_rsp_msg) == 16'd6 && pu_req_valid, "R3 response bypass",
        {pu_rsp_valid, pu_req_valid}, 64'h3);
    idle_nx(); repeat (3) step();

    // R5: request held behind same-address response
    idle_nx(); nx_pu_rsp_ready = 0;
    nx_cu_valid[3] = 1; nx_cu_msg[3] = mk(1, 7, 32'h70); step();
    nx_cu_msg[3] = mk(0, 7, 32'h71); step();
    nx_cu_valid = '0; step();
    chk(!pu_req_valid, "R5 request held", 64'(pu_req_valid), 0);
    idle_nx(); step();
    chk(!pu_req_valid, "R5 held until response gone", 64'(pu_req_valid), 0);
    step();
    chk(pu_req_valid && addr_of(pu_req_msg) == 16'd7, "R5 request released", 64'(pu_req_valid), 1);
    repeat (3) step();

    run_phase("mixed", 2500, 50, 50, 80, 0);
    run_phase("bypass", 1500, 60, 50, 10, 0);
    run_phase("isolation", 1500, 50, 50, 90, 1);
    run_phase("backpressure", 1500, 90, 50, 15, 0);
    run_phase("fairness", 1500, 100, 0, 100, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired in phase %s, actual=running expected=finished", phase);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule